// File: doc/BRIEF.md
# Multichannel PWM with Shadowed Edge Updates

This block drives a bank of pulse width modulated outputs from one shared time base. A prescaler divides the clock into counting ticks. A period counter advances on each tick and returns to zero after it reaches a programmable limit. Every channel holds two edge positions, a rise and a fall. Its output is high while the counter lies in the half-open window between them.

Software reaches the block through a plain one-cycle register write port. Each channel can be built, through a per-channel elaboration mask bit, with a second copy of its two edge registers. While the runtime synchronous switch is on, writes to such a channel collect in the copy, and both edges move into the live registers together when the counter wraps. Channels built without the copy, and all channels while the switch is off, take a write on the next clock. A per-channel inversion bit flips each output.

Top module: `pwm_shadow_top`

## Requirements
- R1: While reset is asserted and after it is released, every register reads zero, synchronous mode is off and every output is low.
- R2: The period counter advances once every P+1 clocks, where P is the prescale register value.
- R3: After the counter has taken the value held in the period register, the next counting tick returns it to zero. That tick is the wrap.
- R4: A channel's raw output is 1 exactly when rise <= count < fall. Equal rise and fall give a constant low, and so does a rise above the fall.
- R5: Bit c of the inversion register (address 3) inverts the output of channel c.
- R6: With synchronous mode off, an edge write changes the output from the clock after the write.
- R7: A channel whose SHADOW_MASK bit is 0 takes edge writes on the next clock even while synchronous mode is on.
- R8: For a channel whose SHADOW_MASK bit is 1, with synchronous mode on, edge writes leave the live edges unchanged until the next wrap. At that wrap both live edges take the latest buffered values.
- R9: A buffered edge write sampled in the same clock as a wrap is not applied at that wrap. It is applied at the following wrap.
- R10: The write map is: address 0 prescale, 1 period, 2 synchronous enable (data bit 0), 3 inversion mask, 4+2c rise of channel c, 5+2c fall of channel c. Edge and period values come from the low CNT_W data bits. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Register write data |
| pwmOut | output | NUM_CH | Channel outputs after inversion |

## Verification
The bench sweeps every rise/fall pair of a 4-bit counter on one channel. This separates the in-window, equal-edge and inverted-edge cases of the comparator. Prescale and period values are then varied to expose the tick and wrap timing. The bench builds shadowing into only half of the channels, so the same writes with synchronous mode on show held updates on one half and immediate updates on the other. Writes placed exactly on the wrap clock check that a value arriving on the boundary waits one more period. Writes to unused addresses must leave every output as it was.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  // Strobes from the control section to the channel datapath
  typedef struct packed {
    logic wrap;    // counter returns to zero on this clock
    logic syncOn;  // buffered-update mode enabled
    logic riseWr;  // write to the selected channel's rise edge
    logic fallWr;  // write to the selected channel's fall edge
  } pwm_strobe_t;
endpackage

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output pwm_strobe_t       strb,
  output logic [CH_W-1:0]   chanSel,
  output logic [CNT_W-1:0]  edgeVal,
  output logic [CNT_W-1:0]  cnt,
  output logic [NUM_CH-1:0] invMask
);
  localparam int ADDR_PRE   = 0;
  localparam int ADDR_PER   = 1;
  localparam int ADDR_SYNC  = 2;
  localparam int ADDR_INV   = 3;
  localparam int ADDR_EDGE0 = 4;
  localparam int ADDR_END   = ADDR_EDGE0 + 2 * NUM_CH;

  logic [PRE_W-1:0] preLimit;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] perLimit;
  logic             syncOn;
  logic             tick;
  logic             wrap;
  logic             edgeHit;
  int               addrInt;

  assign addrInt = int'(wrAddr);
  assign edgeHit = wrEn && (addrInt >= ADDR_EDGE0) && (addrInt < ADDR_END);
  assign chanSel = CH_W'((addrInt - ADDR_EDGE0) >> 1);
  assign edgeVal = wrData[CNT_W-1:0];

  assign tick = (preCnt >= preLimit);
  assign wrap = tick && (cnt >= perLimit);

  assign strb.wrap   = wrap;
  assign strb.syncOn = syncOn;
  assign strb.riseWr = edgeHit && !wrAddr[0];
  assign strb.fallWr = edgeHit &&  wrAddr[0];

  // Time base: prescaler and period counter
  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      cnt    <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // Shared configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      preLimit <= '0;
      perLimit <= '0;
      syncOn   <= 1'b0;
      invMask  <= '0;
    end else if (wrEn) begin
      case (addrInt)
        ADDR_PRE:  preLimit <= wrData[PRE_W-1:0];
        ADDR_PER:  perLimit <= wrData[CNT_W-1:0];
        ADDR_SYNC: syncOn   <= wrData[0];
        ADDR_INV:  invMask  <= wrData[NUM_CH-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
#(
  parameter int          NUM_CH      = 16,
  parameter int          CNT_W       = 8,
  parameter logic [15:0] SHADOW_MASK = 16'h0F0F,
  localparam int         CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pwm_strobe_t                   strb,
  input  logic [CH_W-1:0]               chanSel,
  input  logic [CNT_W-1:0]              edgeVal,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [NUM_CH-1:0]             invMask,
  output logic [NUM_CH-1:0][CNT_W-1:0]  riseAct,
  output logic [NUM_CH-1:0][CNT_W-1:0]  fallAct,
  output logic [NUM_CH-1:0]             pwmOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic riseHit;
    logic fallHit;
    logic inWindow;

    assign riseHit  = strb.riseWr && (int'(chanSel) == ch);
    assign fallHit  = strb.fallWr && (int'(chanSel) == ch);
    assign inWindow = (cnt >= riseAct[ch]) && (cnt < fallAct[ch]);
    assign pwmOut[ch] = inWindow ^ invMask[ch];

    if (SHADOW_MASK[ch]) begin : g_buf
      logic [CNT_W-1:0] riseBuf;
      logic [CNT_W-1:0] fallBuf;

      always_ff @(posedge clk) begin
        if (rst) begin
          riseBuf     <= '0;
          fallBuf     <= '0;
          riseAct[ch] <= '0;
          fallAct[ch] <= '0;
        end else begin
          // commit takes the buffer as it stood before this clock
          if (strb.wrap) begin
            riseAct[ch] <= riseBuf;
            fallAct[ch] <= fallBuf;
          end
          if (riseHit) begin
            riseBuf <= edgeVal;
            if (!strb.syncOn) riseAct[ch] <= edgeVal;
          end
          if (fallHit) begin
            fallBuf <= edgeVal;
            if (!strb.syncOn) fallAct[ch] <= edgeVal;
          end
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          riseAct[ch] <= '0;
          fallAct[ch] <= '0;
        end else begin
          if (riseHit) riseAct[ch] <= edgeVal;
          if (fallHit) fallAct[ch] <= edgeVal;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
  import pwm_shadow_pkg::*;
#(
  parameter int          NUM_CH      = 16,
  parameter int          CNT_W       = 8,
  parameter int          PRE_W       = 8,
  parameter int          DATA_W      = 16,
  parameter logic [15:0] SHADOW_MASK = 16'h0F0F,
  localparam int         ADDR_W      = $clog2(4 + 2 * NUM_CH),
  localparam int         CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_CH-1:0] pwmOut
);
  pwm_strobe_t                  strb;
  logic [CH_W-1:0]              chanSel;
  logic [CNT_W-1:0]             edgeVal;
  logic [CNT_W-1:0]             cnt;
  logic [NUM_CH-1:0]            invMask;
  logic [NUM_CH-1:0][CNT_W-1:0] riseAct;
  logic [NUM_CH-1:0][CNT_W-1:0] fallAct;

  pwm_shadow_ctrl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .chanSel(chanSel), .edgeVal(edgeVal), .cnt(cnt),
    .invMask(invMask)
  );

  pwm_shadow_chan #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .SHADOW_MASK(SHADOW_MASK)
  ) chan_i (
    .clk(clk), .rst(rst), .strb(strb), .chanSel(chanSel),
    .edgeVal(edgeVal), .cnt(cnt), .invMask(invMask),
    .riseAct(riseAct), .fallAct(fallAct), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_shadow_sva.sv
module pwm_shadow_sva #(
  parameter int          NUM_CH      = 16,
  parameter int          CNT_W       = 8,
  parameter logic [15:0] SHADOW_MASK = 16'h0F0F,
  localparam int         CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wrap,
  input logic                         syncOn,
  input logic                         riseWr,
  input logic                         fallWr,
  input logic [CH_W-1:0]              chanSel,
  input logic [CNT_W-1:0]             edgeVal,
  input logic [CNT_W-1:0]             cnt,
  input logic [NUM_CH-1:0]            invMask,
  input logic [NUM_CH-1:0][CNT_W-1:0] riseAct,
  input logic [NUM_CH-1:0][CNT_W-1:0] fallAct,
  input logic [NUM_CH-1:0]            pwmOut
);
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (pwmOut == '0)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0))); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0)); // R3

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (rst)
      (riseAct[ch] == fallAct[ch]) |-> (pwmOut[ch] == invMask[ch])); // R4

    if (SHADOW_MASK[ch]) begin : g_buf
      AST_HOLD_UNTIL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (syncOn && !wrap) |=> ($stable(riseAct[ch]) && $stable(fallAct[ch]))); // R8
    end else begin : g_direct
      AST_DIRECT_RISE: assert property (@(posedge clk) disable iff (rst)
        (riseWr && (int'(chanSel) == ch)) |=> (riseAct[ch] == $past(edgeVal))); // R7
      AST_DIRECT_FALL: assert property (@(posedge clk) disable iff (rst)
        (fallWr && (int'(chanSel) == ch)) |=> (fallAct[ch] == $past(edgeVal))); // R7
    end
  end
endmodule

bind pwm_shadow_top pwm_shadow_sva #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .SHADOW_MASK(SHADOW_MASK)
) sva_i (
  .clk(clk), .rst(rst), .wrap(strb.wrap), .syncOn(strb.syncOn),
  .riseWr(strb.riseWr), .fallWr(strb.fallWr), .chanSel(chanSel),
  .edgeVal(edgeVal), .cnt(cnt), .invMask(invMask),
  .riseAct(riseAct), .fallAct(fallAct), .pwmOut(pwmOut)
);

// File: tb/pwm_shadow_top_tb_top.sv
module pwm_shadow_top_tb_top;
  localparam int          NUM_CH = 16;
  localparam int          CNT_W  = 4;
  localparam int          PRE_W  = 4;
  localparam int          DATA_W = 16;
  localparam logic [15:0] SHMASK = 16'h00FF;
  localparam int          ADDR_W = $clog2(4 + 2 * NUM_CH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [NUM_CH-1:0] pwmOut;

  always #5 clk = ~clk;

  pwm_shadow_top #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W),
    .DATA_W(DATA_W), .SHADOW_MASK(SHMASK)
  ) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut)
  );

  // Reference model built from the requirements
  int               mPre, mCnt, mPrescale, mPeriod;
  bit               mSync;
  logic [NUM_CH-1:0] mInv;
  int               rA [NUM_CH];
  int               fA [NUM_CH];
  int               rS [NUM_CH];
  int               fS [NUM_CH];

  always @(posedge clk) begin
    if (rst) begin
      mPre = 0; mCnt = 0; mPrescale = 0; mPeriod = 0; mSync = 0; mInv = '0;
      for (int c = 0; c < NUM_CH; c++) begin
        rA[c] = 0; fA[c] = 0; rS[c] = 0; fS[c] = 0;
      end
    end else begin
      automatic bit tk = (mPre >= mPrescale);
      automatic bit wr = tk && (mCnt >= mPeriod);
      automatic int a = int'(wrAddr);
      automatic int d = int'(wrData);
      mPre = tk ? 0 : mPre + 1;
      if (tk) mCnt = wr ? 0 : mCnt + 1;
      for (int c = 0; c < NUM_CH; c++)
        if (wr && SHMASK[c]) begin rA[c] = rS[c]; fA[c] = fS[c]; end
      if (wrEn) begin
        if (a == 0) mPrescale = d % 16;
        else if (a == 1) mPeriod = d % 16;
        else if (a == 2) mSync = wrData[0];
        else if (a == 3) mInv = wrData[NUM_CH-1:0];
        else if (a < 4 + 2 * NUM_CH) begin
          automatic int c = (a - 4) / 2;
          automatic int v = d % 16;
          if (a % 2 == 0) begin
            rS[c] = v;
            if (!SHMASK[c] || !mSync) rA[c] = v;
          end else begin
            fS[c] = v;
            if (!SHMASK[c] || !mSync) fA[c] = v;
          end
        end
      end
    end
  end

  function automatic logic [NUM_CH-1:0] expOut();
    logic [NUM_CH-1:0] e;
    for (int c = 0; c < NUM_CH; c++)
      e[c] = ((mCnt >= rA[c]) && (mCnt < fA[c])) ^ mInv[c];
    return e;
  endfunction

  int    checks = 0;
  int    failures = 0;
  bit    chkOn = 0;
  bit    done = 0;
  string curTag = "R1";

  // Cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (chkOn && !done) begin
      checks++;
      if (pwmOut !== expOut()) begin
        failures++;
        $display("FAIL %s cnt=%0d actual=%h expected=%h", curTag, mCnt, pwmOut, expOut());
      end
    end
  end

  task automatic wrReg(input int a, input int d);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = DATA_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    idle(3);
    // R1: outputs low while in reset
    checks++;
    if (pwmOut !== '0) begin
      failures++;
      $display("FAIL R1 in reset actual=%h expected=0", pwmOut);
    end
    rst = 1'b0;
    idle(2);
    // R1: outputs low after reset release
    checks++;
    if (pwmOut !== '0) begin
      failures++;
      $display("FAIL R1 after reset actual=%h expected=0", pwmOut);
    end
    chkOn = 1;

    // R4: sweep every rise/fall pair on channel 3 over a full period
    curTag = "R4";
    wrReg(1, 15);
    for (int r = 0; r < 16; r++)
      for (int f = 0; f < 16; f++) begin
        wrReg(4 + 2 * 3, r);
        wrReg(5 + 2 * 3, f);
        idle(16);
      end

    // R10: writes to unused addresses change nothing
    curTag = "R10";
    for (int a = 4 + 2 * NUM_CH; a < (1 << ADDR_W); a++) wrReg(a, 16'hFFFF);
    idle(20);

    // R5: distinct windows on all channels plus an inversion mask
    curTag = "R5";
    for (int c = 0; c < NUM_CH; c++) begin
      wrReg(4 + 2 * c, c % 5);
      wrReg(5 + 2 * c, (c % 7) + 3);
    end
    wrReg(3, 16'hA5A5);
    idle(40);
    wrReg(3, 16'h0F3C);
    idle(20);
    wrReg(3, 0);

    // R2: prescaler divides the counting rate
    curTag = "R2";
    wrReg(0, 2);
    idle(100);
    wrReg(0, 3);
    wrReg(1, 9);
    idle(120);

    // R3: shorter period wraps earlier
    curTag = "R3";
    wrReg(0, 0);
    wrReg(1, 5);
    idle(30);
    wrReg(1, 15);
    idle(20);

    // R6: immediate updates with synchronous mode off
    curTag = "R6";
    wrReg(4 + 2 * 1, 6);
    idle(3);
    wrReg(5 + 2 * 1, 12);
    idle(5);
    wrReg(4 + 2 * 1, 1);
    idle(20);

    // R8: buffered channels hold edge writes until the wrap
    curTag = "R8";
    wrReg(2, 1);
    wrReg(4 + 2 * 0, 2);
    idle(2);
    wrReg(5 + 2 * 0, 9);
    wrReg(4 + 2 * 5, 10);
    wrReg(5 + 2 * 5, 14);
    idle(40);

    // R7: unbuffered channels follow writes at once in synchronous mode
    curTag = "R7";
    wrReg(4 + 2 * 12, 3);
    idle(2);
    wrReg(5 + 2 * 12, 13);
    wrReg(4 + 2 * 9, 7);
    wrReg(5 + 2 * 9, 8);
    idle(20);

    // R9: buffered writes landing on the wrap clock wait one more period
    curTag = "R9";
    while (!(mPre >= mPrescale && mCnt >= mPeriod)) @(negedge clk);
    wrReg(4 + 2 * 2, 4);
    idle(20);
    while (!(mPre >= mPrescale && mCnt >= mPeriod)) @(negedge clk);
    wrReg(5 + 2 * 2, 11);
    idle(40);

    // R6: switching synchronous mode off restores immediate updates
    curTag = "R6";
    wrReg(2, 0);
    wrReg(4 + 2 * 4, 5);
    wrReg(5 + 2 * 4, 6);
    idle(20);

    finishRun();
  end
endmodule